// File: doc/BRIEF.md
# Taint Propagation Result Cache

This block remembers what a software taint-propagation routine answered for a given combination of inputs, so that the routine only has to run once per distinct combination. A lookup is presented as an instruction opcode together with three source taint states (first register operand, second register operand, memory operand). The block folds these into a 7-bit index into a 128-entry direct-mapped table. Every entry keeps the full key as its tag, plus the output taint state and an exception flag that the routine produced.

On a hit the stored answer comes back on the response stream. On a miss the block raises a handler request carrying the four inputs and waits for a fill. The fill is passed straight through to the response stream and written into the table in the same handshake. A write to the handler-address register changes which routine is valid, so it clears the whole table. Per-word taint width is a parameter (1 to 16 bits, default 2) and the opcode width is a parameter (default 8).

Requests, responses and fills are valid/ready streams. A source keeps its valid high and its payload unchanged until ready is seen with it. The block holds `rsp_valid` and the response payload steady while `rsp_ready` is low. Only one lookup is in flight at a time. The handler-address write strobe is a plain control pin.

Top module: `taint_result_cache`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `rsp_valid` and `hreq_valid` are 0, and every entry is empty, so the first lookup of any key misses.
- R2: The key is `{opcode, src1, src2, mem}` with the opcode in the most significant bits. Index bit j (0..6) is the XOR of key bits j, j+7, j+14, and so on.
- R3: `req_ready` is high only when no lookup is in flight, so one request is in flight at most. On a hit, `rsp_valid` rises in the cycle after the request is accepted, carrying the stored state and exception bit.
- R4: A hit requires the whole stored key to equal the request key. A different key that folds to the same index misses, and its fill replaces the entry.
- R5: On a miss, `hreq_valid` rises two cycles after acceptance. It stays high, with `hreq_*` equal to the accepted request fields, until a fill is accepted.
- R6: While a handler request is open, `rsp_valid` follows `fill_valid`, the response payload equals the fill payload, and `fill_ready` equals `rsp_ready`. An accepted fill is stored, and the block accepts a new request in the next cycle.
- R7: A hit response held under back-pressure keeps its state and exception bit unchanged until `rsp_ready` is seen.
- R8: A pulse on `handler_ptr_wr` in cycle t empties every entry from cycle t+1. A request accepted in cycle t is answered as a miss.
- R9: A fill accepted in the same cycle as `handler_ptr_wr` is still returned on the response stream but is not kept.
- R10: A hit response already presented is delivered unchanged even if `handler_ptr_wr` pulses while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| handler_ptr_wr | input | 1 | Handler-address register write strobe; flushes the table |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request ready |
| req_opcode | input | OPC_W | Request opcode |
| req_src1 | input | ST_W | Taint state of register operand 1 |
| req_src2 | input | ST_W | Taint state of register operand 2 |
| req_mem | input | ST_W | Taint state of memory operand |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_state | output | ST_W | Resulting taint state |
| rsp_exc | output | 1 | Raise-exception flag |
| hreq_valid | output | 1 | Handler invocation requested |
| hreq_opcode | output | OPC_W | Opcode for the handler |
| hreq_src1 | output | ST_W | Register operand 1 state for the handler |
| hreq_src2 | output | ST_W | Register operand 2 state for the handler |
| hreq_mem | output | ST_W | Memory operand state for the handler |
| fill_valid | input | 1 | Handler answer valid |
| fill_ready | output | 1 | Handler answer accepted |
| fill_state | input | ST_W | Handler's output taint state |
| fill_exc | input | 1 | Handler's exception flag |

## Verification
If a valid bit or tag is corrupted, the next lookup of that key shows it within two cycles of acceptance. A stale or aliased entry appears as a hit with the wrong payload in the cycle after acceptance. A lost entry appears as a handler request where a hit was due. A flush that does not clear, or that clears late, shows the same way on the first repeat lookup after the strobe. The bench therefore runs a small key pool rich in index aliases, many times over, under random back-pressure and flush strobes. The control state machine is compared with a reference model on every clock, so a handshake that is missing or extra is caught in the same cycle.

// File: rtl/taint_cache_pkg.sv
package taint_cache_pkg;

  // Controller phases of one lookup.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // ready for a request
    ST_LOOK = 2'd1,   // entry read back, tag compared
    ST_HOLD = 2'd2,   // hit answer waiting for rsp_ready
    ST_MISS = 2'd3    // handler request open, waiting for fill
  } tc_state_e;

endpackage

// File: rtl/taint_key_fold.sv
// XOR-folds a key of arbitrary width down to an index.
module taint_key_fold #(
  parameter int KEY_W = 14,
  parameter int IDX_W = 7
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx
);

  localparam int SLICES = (KEY_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = SLICES * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] acc [SLICES+1];

  assign padded = PAD_W'(key);
  assign acc[0] = '0;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    assign acc[s+1] = acc[s] ^ padded[s*IDX_W +: IDX_W];
  end

  assign idx = acc[SLICES];

endmodule

// File: rtl/taint_entry_store.sv
// Entry array: flushable valid bits plus tag/answer words, registered read.
module taint_entry_store #(
  parameter int DEPTH  = 128,
  parameter int IDX_W  = 7,
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  output logic              rd_valid_q,
  output logic [WORD_W-1:0] rd_word_q
);

  logic [DEPTH-1:0]  valid_q;
  logic [WORD_W-1:0] mem_q [DEPTH];

  // Flush wins over a simultaneous write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      mem_q[wr_idx] <= wr_word;
    end
  end

  // Read captures the state before any flush or write on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
    end else if (rd_en) begin
      rd_valid_q <= valid_q[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_word_q <= mem_q[rd_idx];
    end
  end

endmodule

// File: rtl/taint_cache_ctrl.sv
// Lookup sequencer: accept, compare, answer or call the handler.
module taint_cache_ctrl
  import taint_cache_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rsp_ready,
  input  logic fill_valid,
  input  logic flush,
  input  logic entry_match,
  output logic req_ready,
  output logic rsp_valid,
  output logic fill_ready,
  output logic hreq_valid,
  output logic rsp_from_fill,
  output logic rd_en,
  output logic wr_en
);

  tc_state_e state_q, state_d;
  logic      kill_q;
  logic      look_hit;

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    rd_en         = req_ready && req_valid;
    look_hit      = (state_q == ST_LOOK) && entry_match && !kill_q;
    hreq_valid    = (state_q == ST_MISS);
    rsp_from_fill = hreq_valid;
    fill_ready    = hreq_valid && rsp_ready;
    wr_en         = fill_valid && fill_ready;
    rsp_valid     = look_hit || (state_q == ST_HOLD) || (hreq_valid && fill_valid);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (rd_en) state_d = ST_LOOK;
      ST_LOOK: begin
        if (look_hit) state_d = rsp_ready ? ST_IDLE : ST_HOLD;
        else          state_d = ST_MISS;
      end
      ST_HOLD: if (rsp_ready) state_d = ST_IDLE;
      ST_MISS: if (wr_en) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kill_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      // The read that races a flush on the same edge must not hit.
      if (rd_en) kill_q <= flush;
    end
  end

endmodule

// File: rtl/taint_result_cache.sv
module taint_result_cache #(
  parameter int OPC_W   = 8,
  parameter int ST_W    = 2,
  parameter int ENTRIES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             handler_ptr_wr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OPC_W-1:0] req_opcode,
  input  logic [ST_W-1:0]  req_src1,
  input  logic [ST_W-1:0]  req_src2,
  input  logic [ST_W-1:0]  req_mem,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [ST_W-1:0]  rsp_state,
  output logic             rsp_exc,
  output logic             hreq_valid,
  output logic [OPC_W-1:0] hreq_opcode,
  output logic [ST_W-1:0]  hreq_src1,
  output logic [ST_W-1:0]  hreq_src2,
  output logic [ST_W-1:0]  hreq_mem,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [ST_W-1:0]  fill_state,
  input  logic             fill_exc
);

  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int KEY_W  = OPC_W + 3 * ST_W;
  localparam int DATA_W = ST_W + 1;
  localparam int WORD_W = KEY_W + DATA_W;

  logic [KEY_W-1:0]  req_key, key_q, rd_tag;
  logic [IDX_W-1:0]  req_idx, key_idx;
  logic [WORD_W-1:0] rd_word;
  logic [ST_W-1:0]   rd_state;
  logic              rd_exc, rd_valid;
  logic              entry_match, rsp_from_fill, rd_en, wr_en;

  assign req_key = {req_opcode, req_src1, req_src2, req_mem};

  taint_key_fold #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_fold_req (
    .key (req_key),
    .idx (req_idx)
  );

  taint_key_fold #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_fold_held (
    .key (key_q),
    .idx (key_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) key_q <= '0;
    else if (rd_en) key_q <= req_key;
  end

  taint_entry_store #(.DEPTH(ENTRIES), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (handler_ptr_wr),
    .rd_en      (rd_en),
    .rd_idx     (req_idx),
    .wr_en      (wr_en),
    .wr_idx     (key_idx),
    .wr_word    ({key_q, fill_state, fill_exc}),
    .rd_valid_q (rd_valid),
    .rd_word_q  (rd_word)
  );

  assign {rd_tag, rd_state, rd_exc} = rd_word;
  assign entry_match = rd_valid && (rd_tag == key_q);

  taint_cache_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .rsp_ready     (rsp_ready),
    .fill_valid    (fill_valid),
    .flush         (handler_ptr_wr),
    .entry_match   (entry_match),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .fill_ready    (fill_ready),
    .hreq_valid    (hreq_valid),
    .rsp_from_fill (rsp_from_fill),
    .rd_en         (rd_en),
    .wr_en         (wr_en)
  );

  assign rsp_state = rsp_from_fill ? fill_state : rd_state;
  assign rsp_exc   = rsp_from_fill ? fill_exc   : rd_exc;

  assign {hreq_opcode, hreq_src1, hreq_src2, hreq_mem} = key_q;

endmodule

// File: rtl/taint_cache_chk.sv
module taint_cache_chk #(
  parameter int OPC_W = 8,
  parameter int ST_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             handler_ptr_wr,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OPC_W-1:0] req_opcode,
  input logic [ST_W-1:0]  req_src1,
  input logic [ST_W-1:0]  req_src2,
  input logic [ST_W-1:0]  req_mem,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [ST_W-1:0]  rsp_state,
  input logic             rsp_exc,
  input logic             hreq_valid,
  input logic [OPC_W-1:0] hreq_opcode,
  input logic [ST_W-1:0]  hreq_src1,
  input logic [ST_W-1:0]  hreq_src2,
  input logic [ST_W-1:0]  hreq_mem,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic [ST_W-1:0]  fill_state,
  input logic             fill_exc
);

  localparam int KEY_W = OPC_W + 3 * ST_W;

  logic [KEY_W-1:0] key_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) key_seen <= '0;
    else if (req_valid && req_ready) key_seen <= {req_opcode, req_src1, req_src2, req_mem};
  end

  // R3
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  hreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq_valid && !(fill_valid && fill_ready)) |=>
      (hreq_valid && $stable(hreq_opcode) && $stable(hreq_src1) &&
       $stable(hreq_src2) && $stable(hreq_mem)));

  // R5
  hreq_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid |-> ({hreq_opcode, hreq_src1, hreq_src2, hreq_mem} == key_seen));

  // R6
  fill_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |->
      (rsp_valid && rsp_ready && rsp_state == fill_state && rsp_exc == fill_exc));

  // R7
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !hreq_valid) |=>
      (rsp_valid && $stable(rsp_state) && $stable(rsp_exc)));

  // R8
  flush_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && handler_ptr_wr) |=> !rsp_valid);

endmodule

bind taint_result_cache taint_cache_chk #(.OPC_W(OPC_W), .ST_W(ST_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .handler_ptr_wr (handler_ptr_wr),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_opcode     (req_opcode),
  .req_src1       (req_src1),
  .req_src2       (req_src2),
  .req_mem        (req_mem),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_state      (rsp_state),
  .rsp_exc        (rsp_exc),
  .hreq_valid     (hreq_valid),
  .hreq_opcode    (hreq_opcode),
  .hreq_src1      (hreq_src1),
  .hreq_src2      (hreq_src2),
  .hreq_mem       (hreq_mem),
  .fill_valid     (fill_valid),
  .fill_ready     (fill_ready),
  .fill_state     (fill_state),
  .fill_exc       (fill_exc)
);

// File: tb/taint_result_cache_tb.sv
module taint_result_cache_tb;

  localparam int OPC_W = 8;
  localparam int ST_W  = 2;
  localparam int KEY_W = OPC_W + 3 * ST_W;
  localparam int NENT  = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic handler_ptr_wr = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [OPC_W-1:0] req_opcode = '0;
  logic [ST_W-1:0]  req_src1 = '0, req_src2 = '0, req_mem = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [ST_W-1:0] rsp_state;
  logic rsp_exc;
  logic hreq_valid;
  logic [OPC_W-1:0] hreq_opcode;
  logic [ST_W-1:0]  hreq_src1, hreq_src2, hreq_mem;
  logic fill_valid = 1'b0;
  logic fill_ready;
  logic [ST_W-1:0] fill_state = '0;
  logic fill_exc = 1'b0;

  always #5 clk = ~clk;

  taint_result_cache #(.OPC_W(OPC_W), .ST_W(ST_W), .ENTRIES(NENT)) u_dut (
    .clk(clk), .rst_n(rst_n), .handler_ptr_wr(handler_ptr_wr),
    .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
    .req_src1(req_src1), .req_src2(req_src2), .req_mem(req_mem),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_state(rsp_state), .rsp_exc(rsp_exc),
    .hreq_valid(hreq_valid), .hreq_opcode(hreq_opcode), .hreq_src1(hreq_src1),
    .hreq_src2(hreq_src2), .hreq_mem(hreq_mem),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_state(fill_state), .fill_exc(fill_exc)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, expv, $time);
    end
  endtask

  // Behavioural index: bit i of the key toggles index bit i mod 7 (R2).
  function automatic int fold_idx(logic [KEY_W-1:0] k);
    int r = 0;
    for (int i = 0; i < KEY_W; i++) if (k[i]) r = r ^ (1 << (i % 7));
    return r;
  endfunction

  // Reference contents
  bit                c_val [NENT];
  logic [KEY_W-1:0]  c_tag [NENT];
  logic [ST_W-1:0]   c_st  [NENT];
  bit                c_ex  [NENT];

  // Reference sequencer: 0 idle, 1 compare, 2 holding hit, 3 handler open
  int               m_st = 0;
  logic [KEY_W-1:0] m_key;
  bit               m_hit, m_kill, m_ex;
  logic [ST_W-1:0]  m_ds;
  bit               running = 0;
  bit               req_acc = 0, fill_acc = 0;
  int               stall = 0;

  int cov_hit = 0, cov_miss = 0, cov_alias = 0, cov_kill = 0;
  int cov_fillflush = 0, cov_hold = 0, cov_holdflush = 0, cov_refill_hit = 0;

  always @(negedge clk) begin
    if (running) begin
      bit e_rr, e_rv, e_hv, e_fr;
      logic [ST_W-1:0] e_s;
      bit e_x;
      logic [KEY_W-1:0] ck;
      int ix;
      e_rr = 0; e_rv = 0; e_hv = 0; e_fr = 0; e_s = '0; e_x = 0;
      case (m_st)
        0: e_rr = 1;
        1: begin e_rv = m_hit && !m_kill; e_s = m_ds; e_x = m_ex; end
        2: begin e_rv = 1; e_s = m_ds; e_x = m_ex; end
        default: begin e_hv = 1; e_rv = fill_valid; e_fr = rsp_ready; e_s = fill_state; e_x = fill_exc; end
      endcase
      chk(req_ready === e_rr, "R3 req_ready", 32'(req_ready), 32'(e_rr));
      chk(rsp_valid === e_rv, (m_st == 1 && m_kill) ? "R8 rsp_valid" : "R2 R4 rsp_valid",
          32'(rsp_valid), 32'(e_rv));
      if (e_rv) chk({rsp_state, rsp_exc} === {e_s, e_x},
                    (m_st == 3) ? "R6 rsp payload" : "R4 R7 R10 rsp payload",
                    32'({rsp_state, rsp_exc}), 32'({e_s, e_x}));
      chk(hreq_valid === e_hv, "R5 hreq_valid", 32'(hreq_valid), 32'(e_hv));
      if (e_hv) chk({hreq_opcode, hreq_src1, hreq_src2, hreq_mem} === m_key, "R5 hreq key",
                    32'({hreq_opcode, hreq_src1, hreq_src2, hreq_mem}), 32'(m_key));
      chk(fill_ready === e_fr, "R6 fill_ready", 32'(fill_ready), 32'(e_fr));

      req_acc  = req_valid && e_rr;
      fill_acc = fill_valid && e_fr;
      if (e_rv && rsp_ready) stall = 0; else stall++;

      case (m_st)
        0: if (req_valid) begin
          ck = {req_opcode, req_src1, req_src2, req_mem};
          ix = fold_idx(ck);
          m_key = ck;
          m_hit = c_val[ix] && c_tag[ix] == ck;
          m_ds = c_st[ix]; m_ex = c_ex[ix];
          m_kill = handler_ptr_wr;
          if (m_kill && m_hit) cov_kill++;
          if (c_val[ix] && c_tag[ix] != ck) cov_alias++;
          m_st = 1;
        end
        1: begin
          if (m_hit && !m_kill) begin
            cov_hit++;
            m_st = rsp_ready ? 0 : 2;
            if (!rsp_ready) cov_hold++;
          end else begin
            cov_miss++;
            m_st = 3;
          end
        end
        2: begin
          if (handler_ptr_wr) cov_holdflush++;
          if (rsp_ready) m_st = 0;
        end
        default: if (fill_valid && rsp_ready) begin
          ix = fold_idx(m_key);
          if (handler_ptr_wr) cov_fillflush++;
          else begin
            c_val[ix] = 1; c_tag[ix] = m_key; c_st[ix] = fill_state; c_ex[ix] = fill_exc;
          end
          m_st = 0;
        end
      endcase
      if (handler_ptr_wr) for (int i = 0; i < NENT; i++) c_val[i] = 0;
    end
  end

  // Watchdog: a response handshake must happen regularly.
  always @(negedge clk) begin
    if (running && stall > 3000) begin
      total++; bad++;
      $display("FAIL R3 watchdog actual=%0d expected=0", stall);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [KEY_W-1:0] pool [8];
  int gen = 0;

  function automatic logic [ST_W+1-1:0] handler_ans(logic [KEY_W-1:0] k, int g);
    logic [ST_W-1:0] s;
    s = ST_W'(k[3:0] ^ k[13:10] ^ 4'(g));
    return {s, ^k ^ g[0]};
  endfunction

  initial begin
    pool[0] = 14'h0123; pool[1] = 14'h0123 ^ 14'h0081;
    pool[2] = 14'h2A5C; pool[3] = 14'h2A5C ^ 14'h0102 ^ 14'h0100 ^ 14'h0001;
    pool[4] = 14'h3FFF; pool[5] = 14'h3FFF ^ 14'h2000 ^ 14'h0040;
    pool[6] = 14'h0000; pool[7] = 14'h1807;
    for (int i = 0; i < NENT; i++) c_val[i] = 0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1, "R1 req_ready in reset", 32'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
    chk(hreq_valid === 1'b0, "R1 hreq_valid in reset", 32'(hreq_valid), 0);
    chk(fill_ready === 1'b0, "R1 fill_ready in reset", 32'(fill_ready), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    running = 1;

    // First lookup after reset must miss (R1)
    req_valid = 1; {req_opcode, req_src1, req_src2, req_mem} = pool[2];
    @(posedge clk); #1; req_valid = 0;
    @(posedge clk); #1;
    chk(hreq_valid === 1'b1, "R1 first lookup misses", 32'(hreq_valid), 1);

    for (int cyc = 0; cyc < 24000; cyc++) begin
      int phase;
      logic [KEY_W-1:0] k;
      logic [ST_W:0] a;
      phase = cyc / 6000;
      @(posedge clk); #1;
      handler_ptr_wr = (phase >= 2) && ($urandom % 100 < ((phase == 3) ? 12 : 3));
      if (handler_ptr_wr) gen++;
      rsp_ready = (phase == 0) ? 1'b1 : ($urandom % 100 < 60);
      if (!(req_valid && !req_acc)) begin
        req_valid = ($urandom % 100 < 70);
        k = ($urandom % 10 == 0) ? KEY_W'($urandom) : pool[$urandom % 8];
        {req_opcode, req_src1, req_src2, req_mem} = k;
      end
      if (!(fill_valid && !fill_acc)) begin
        if (hreq_valid && ($urandom % 100 < 50)) begin
          fill_valid = 1;
          a = handler_ans({hreq_opcode, hreq_src1, hreq_src2, hreq_mem}, gen);
          {fill_state, fill_exc} = a;
        end else begin
          fill_valid = 0;
        end
      end
    end
    @(posedge clk); #1;
    req_valid = 0; fill_valid = 0; handler_ptr_wr = 0;
    repeat (3) @(posedge clk);
    running = 0;

    chk(cov_hit > 0,       "R3 hits observed", 32'(cov_hit), 1);
    chk(cov_miss > 0,      "R5 misses observed", 32'(cov_miss), 1);
    chk(cov_alias > 0,     "R4 alias lookups observed", 32'(cov_alias), 1);
    chk(cov_kill > 0,      "R8 killed hits observed", 32'(cov_kill), 1);
    chk(cov_fillflush > 0, "R9 fill with flush observed", 32'(cov_fillflush), 1);
    chk(cov_hold > 0,      "R7 held hits observed", 32'(cov_hold), 1);
    chk(cov_holdflush > 0, "R10 flush during held hit observed", 32'(cov_holdflush), 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule